// File: doc/BRIEF.md
# Packed-Symbol Error Correction Applier

This block takes the result of a Reed-Solomon decoder, a short list of error locations given as 12-bit symbol indices with a 12-bit error pattern for each, and writes the corrections into a page buffer. The page sits in a byte-wide RAM. The 2048-byte data area occupies addresses 0 to 2047, and the spare area follows directly from address 2048. The codeword packs its 12-bit symbols three nibbles at a time into bytes. A 4-bit pad sits in front of the first symbol, so symbol 0 covers only byte 0. Every later symbol spans one and a half bytes, and symbol 1365 straddles the last data byte and the first spare byte.

A caller places the pattern list on the inputs and pulses `start`. For each entry, in list order, the block turns the index into one or two byte addresses with their nibble alignment. It then performs one read-modify-write per byte on the RAM, which has one cycle of read latency. When it finishes, it raises `done` for one cycle. At that point `failed` shows whether the page could not be corrected, and `fixed_cnt` shows how many entries were applied. The first entry that cannot be applied stops the run. Corrections that were already written remain in the RAM.

Top module: `rs_packed_fixup`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `failed`, `ram_rd_en` and `ram_wr_en` are 0 and `fixed_cnt` is 0.
- R2: For an odd index p, with a = floor(3p/2), byte a is XORed with pattern bits 11:4, and byte a+1 is XORed with pattern bits 3:0 placed in its high nibble (mask `{pat[3:0],4'h0}`).
- R3: For an even index p > 0, with a = floor(3p/2), byte a-1 is XORed with pattern bits 11:8 placed in its low nibble (mask `{4'h0,pat[11:8]}`), and byte a is XORed with pattern bits 7:0.
- R4: At index 0, a pattern of at most 0xFF is XORed into byte 0 alone. A pattern above 0xFF makes the page fail without any write.
- R5: Index 1365 writes pattern bits 11:4 into byte 2047, the last data byte, and pattern bits 3:0 into the high nibble of byte 2048, the first spare byte.
- R6: Indices 1366 to 1374 follow the odd/even rules and land in the spare area, at spare offset 3p/2 minus 2048, which is RAM address floor(3p/2) or one below it.
- R7: An index above 1374 makes the page fail. That entry and all later entries write nothing, and `fixed_cnt` equals the number of earlier entries applied.
- R8: An error count above 4 makes the page fail with no RAM access.
- R9: Entries are applied in input order, and within an entry the lower address comes first. Each byte update drives `ram_rd_en` for one cycle, then `ram_wr_en` on the next cycle at the same address with `ram_wdata` = read data XOR mask. `fixed_cnt` rises by one in the cycle after an entry's last write.
- R10: `done` is a single-cycle pulse. Counting the cycle right after `start` is sampled as cycle 1, it comes in cycle 2 + the sum of (1 + 2 x bytes) over the entries applied.
- R11: A `start` pulse while `busy` is 1 is ignored. The run in progress is not affected.
- R12: After `done`, `busy` is 0, and `failed` and `fixed_cnt` keep their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| err_count | input | 3 | Number of valid entries in the lists |
| err_pos | input | 48 | Symbol indices, entry i at bits [12i+11:12i] |
| err_pat | input | 48 | Error patterns, entry i at bits [12i+11:12i] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| failed | output | 1 | The page could not be corrected |
| fixed_cnt | output | 3 | Entries applied in the current or last run |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_addr | output | 12 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after the read strobe |

## Verification
After `start`, each entry costs one evaluation cycle, plus a read cycle and a write cycle for each byte it touches. The write data depends on the RAM word returned one cycle after the read strobe. `done` follows one cycle after the final evaluation. At every start, the bench expands the job into a per-cycle list of expected strobes, addresses, write data, counts and flags. It compares that list with the ports at each falling edge, from the first cycle after `start` is sampled through several idle cycles after `done`.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;
    // Symbol width fixed by the three-nibble packing
    localparam int SYM_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_EVAL = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_FIN  = 3'd4
    } fix_state_e;
endpackage

// File: rtl/rs_entry_sel.sv
module rs_entry_sel
    import rs_fix_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IW = $clog2(N_ENT + 1)
) (
    input  logic [N_ENT*SYM_W-1:0] pos_flat,
    input  logic [N_ENT*SYM_W-1:0] pat_flat,
    input  logic [IW-1:0]          sel,
    output logic [SYM_W-1:0]       pos,
    output logic [SYM_W-1:0]       pat
);
    logic [SYM_W-1:0] pos_arr [N_ENT];
    logic [SYM_W-1:0] pat_arr [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_unpack
        assign pos_arr[g] = pos_flat[g*SYM_W +: SYM_W];
        assign pat_arr[g] = pat_flat[g*SYM_W +: SYM_W];
    end

    always_comb begin
        pos = '0;
        pat = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (sel == IW'(i)) begin
                pos = pos_arr[i];
                pat = pat_arr[i];
            end
        end
    end
endmodule

// File: rtl/rs_sym_map.sv
module rs_sym_map
    import rs_fix_pkg::*;
#(
    parameter int LAST_SYM = 1374,
    parameter int ADDR_W   = 12
) (
    input  logic [SYM_W-1:0]  pos,
    input  logic [SYM_W-1:0]  pat,
    output logic              bad,
    output logic              two_bytes,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [7:0]        mask_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic [7:0]        mask_hi
);
    localparam logic [SYM_W-1:0] LAST_C = SYM_W'(LAST_SYM);

    logic [SYM_W+1:0] triple;
    logic [ADDR_W-1:0] half;

    assign triple = {2'b00, pos} + {1'b0, pos, 1'b0};
    assign half   = ADDR_W'(triple[SYM_W+1:1]);

    always_comb begin
        bad       = 1'b0;
        two_bytes = 1'b1;
        addr_lo   = '0;
        mask_lo   = '0;
        addr_hi   = '0;
        mask_hi   = '0;
        if (pos > LAST_C) begin
            bad = 1'b1;
        end else if (pos == '0) begin
            // pad nibble in front: only byte 0 carries symbol bits
            bad       = |pat[11:8];
            two_bytes = 1'b0;
            mask_lo   = pat[7:0];
        end else if (pos[0]) begin
            addr_lo = half;
            mask_lo = pat[11:4];
            addr_hi = half + 1'b1;
            mask_hi = {pat[3:0], 4'h0};
        end else begin
            addr_lo = half - 1'b1;
            mask_lo = {4'h0, pat[11:8]};
            addr_hi = half;
            mask_hi = pat[7:0];
        end
    end
endmodule

// File: rtl/rs_packed_fixup.sv
module rs_packed_fixup
    import rs_fix_pkg::*;
#(
    parameter int MAX_ERR  = 4,
    parameter int LAST_SYM = 1374,
    localparam int CW      = $clog2(MAX_ERR + 1),
    localparam int ADDR_W  = $clog2((3 * LAST_SYM) / 2 + 2),
    localparam int FLAT_W  = MAX_ERR * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     err_count,
    input  logic [FLAT_W-1:0] err_pos,
    input  logic [FLAT_W-1:0] err_pat,
    output logic              busy,
    output logic              done,
    output logic              failed,
    output logic [CW-1:0]     fixed_cnt,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    localparam logic [CW-1:0] MAX_C = CW'(MAX_ERR);

    typedef struct packed {
        fix_state_e        st;
        logic [CW-1:0]     idx;
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     nerr;
        logic              slot;
        logic              fail;
        logic [FLAT_W-1:0] pos;
        logic [FLAT_W-1:0] pat;
    } fix_regs_t;

    fix_regs_t r_q, r_d;

    logic [SYM_W-1:0]  cur_pos, cur_pat;
    logic              m_bad, m_two;
    logic [ADDR_W-1:0] m_addr_lo, m_addr_hi;
    logic [7:0]        m_mask_lo, m_mask_hi;

    rs_entry_sel #(.N_ENT(MAX_ERR)) u_sel (
        .pos_flat (r_q.pos),
        .pat_flat (r_q.pat),
        .sel      (r_q.idx),
        .pos      (cur_pos),
        .pat      (cur_pat)
    );

    rs_sym_map #(.LAST_SYM(LAST_SYM), .ADDR_W(ADDR_W)) u_map (
        .pos       (cur_pos),
        .pat       (cur_pat),
        .bad       (m_bad),
        .two_bytes (m_two),
        .addr_lo   (m_addr_lo),
        .mask_lo   (m_mask_lo),
        .addr_hi   (m_addr_hi),
        .mask_hi   (m_mask_hi)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_EVAL;
                    r_d.nerr = err_count;
                    r_d.pos  = err_pos;
                    r_d.pat  = err_pat;
                    r_d.idx  = '0;
                    r_d.cnt  = '0;
                    r_d.slot = 1'b0;
                    r_d.fail = 1'b0;
                end
            end
            ST_EVAL: begin
                r_d.slot = 1'b0;
                if (r_q.nerr > MAX_C) begin
                    r_d.fail = 1'b1;
                    r_d.st   = ST_FIN;
                end else if (r_q.idx == r_q.nerr) begin
                    r_d.st = ST_FIN;
                end else if (m_bad) begin
                    r_d.fail = 1'b1;
                    r_d.st   = ST_FIN;
                end else begin
                    r_d.st = ST_RD;
                end
            end
            ST_RD: r_d.st = ST_WR;
            ST_WR: begin
                if (!r_q.slot && m_two) begin
                    r_d.slot = 1'b1;
                    r_d.st   = ST_RD;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_EVAL;
                end
            end
            ST_FIN:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_FIN);
    assign failed    = r_q.fail;
    assign fixed_cnt = r_q.cnt;
    assign ram_rd_en = (r_q.st == ST_RD);
    assign ram_wr_en = (r_q.st == ST_WR);
    assign ram_addr  = r_q.slot ? m_addr_hi : m_addr_lo;
    assign ram_wdata = ram_rdata ^ (r_q.slot ? m_mask_hi : m_mask_lo);

    // R9
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> ram_wr_en && $stable(ram_addr));

    // R9
    wr_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> $past(ram_rd_en));

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd_en && ram_wr_en));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    quiet_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> !ram_wr_en && !ram_rd_en);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_cnt <= MAX_C);
endmodule

// File: tb/tb_rs_packed_fixup.sv
module tb_rs_packed_fixup;
    localparam int MAXE = 4;
    localparam int SW   = 12;
    localparam int AW   = 12;
    localparam int CW   = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, start;
    logic [CW-1:0]     err_count;
    logic [MAXE*SW-1:0] err_pos, err_pat;
    logic              busy, done, failed, ram_rd_en, ram_wr_en;
    logic [CW-1:0]     fixed_cnt;
    logic [AW-1:0]     ram_addr;
    logic [7:0]        ram_wdata, ram_rdata;

    rs_packed_fixup dut (
        .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
        .err_pos(err_pos), .err_pat(err_pat), .busy(busy), .done(done),
        .failed(failed), .fixed_cnt(fixed_cnt), .ram_rd_en(ram_rd_en),
        .ram_wr_en(ram_wr_en), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    logic [7:0] mem [0:4095];
    int         model [0:4095];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'((i * 37 + 11) & 255);
            ram_rdata <= 8'h00;
        end else begin
            if (ram_rd_en) ram_rdata <= mem[ram_addr];
            if (ram_wr_en) mem[ram_addr] <= ram_wdata;
        end
    end

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    typedef struct {
        int kind;  // 0 evaluate, 1 read, 2 write, 3 finish
        int addr;
        int mask;
        int cnt;
    } step_t;

    task automatic idle_check(input string tag, input int exp_fail, input int exp_cnt);
        check(busy == 1'b0, tag, "busy", busy, 0);
        check(done == 1'b0, tag, "done", done, 0);
        check(ram_rd_en == 1'b0 && ram_wr_en == 1'b0, tag, "strobes",
              {ram_rd_en, ram_wr_en}, 0);
        check(failed == exp_fail[0], tag, "failed", failed, exp_fail);
        check(fixed_cnt == CW'(exp_cnt), tag, "fixed_cnt", fixed_cnt, exp_cnt);
    endtask

    task automatic run_job(input string tag, input int n, input int p[4],
                           input int pt[4], input bit poke);
        step_t q[$];
        step_t s;
        int c = 0;
        int f = 0;
        int ew;
        if (n > 4) begin
            s = '{0, 0, 0, 0}; q.push_back(s);
            f = 1;
        end else begin
            for (int i = 0; i < n; i++) begin
                s = '{0, 0, 0, c}; q.push_back(s);
                if (p[i] > 1374 || (p[i] == 0 && pt[i] > 255)) begin
                    f = 1;
                    break;
                end
                if (p[i] == 0) begin
                    s = '{1, 0, pt[i], c}; q.push_back(s);
                    s.kind = 2; q.push_back(s);
                end else if (p[i] % 2 == 1) begin
                    s = '{1, (3 * p[i]) / 2, pt[i] >> 4, c}; q.push_back(s);
                    s.kind = 2; q.push_back(s);
                    s = '{1, (3 * p[i]) / 2 + 1, (pt[i] & 15) << 4, c}; q.push_back(s);
                    s.kind = 2; q.push_back(s);
                end else begin
                    s = '{1, (3 * p[i]) / 2 - 1, pt[i] >> 8, c}; q.push_back(s);
                    s.kind = 2; q.push_back(s);
                    s = '{1, (3 * p[i]) / 2, pt[i] & 255, c}; q.push_back(s);
                    s.kind = 2; q.push_back(s);
                end
                c++;
            end
            if (f == 0) begin
                s = '{0, 0, 0, c}; q.push_back(s);
            end
        end
        s = '{3, 0, 0, c}; q.push_back(s);

        @(negedge clk);
        err_count = CW'(n);
        for (int i = 0; i < 4; i++) begin
            err_pos[i*SW +: SW] = SW'(p[i]);
            err_pat[i*SW +: SW] = SW'(pt[i]);
        end
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        foreach (q[k]) begin
            check(busy == 1'b1, tag, "busy", busy, 1);
            check(ram_rd_en == (q[k].kind == 1), tag, "rd_en", ram_rd_en, q[k].kind == 1);
            check(ram_wr_en == (q[k].kind == 2), tag, "wr_en", ram_wr_en, q[k].kind == 2);
            check(done == (q[k].kind == 3), tag, "done", done, q[k].kind == 3);
            check(fixed_cnt == CW'(q[k].cnt), tag, "fixed_cnt", fixed_cnt, q[k].cnt);
            check(failed == ((q[k].kind == 3) ? f[0] : 1'b0), tag, "failed", failed,
                  (q[k].kind == 3) ? f : 0);
            if (q[k].kind == 1 || q[k].kind == 2)
                check(ram_addr == AW'(q[k].addr), tag, "addr", ram_addr, q[k].addr);
            if (q[k].kind == 2) begin
                ew = model[q[k].addr] ^ q[k].mask;
                check(ram_wdata == 8'(ew), tag, "wdata", ram_wdata, ew);
                model[q[k].addr] = ew;
            end
            if (poke && k == 1) begin
                // R11: second start while busy, with different lists
                start     = 1'b1;
                err_count = 3'd1;
                err_pos   = '1;
                err_pat   = '1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        // R12: status holds while idle
        for (int j = 0; j < 3; j++) begin
            idle_check(tag, f, c);
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int bad;
        for (int i = 0; i < 4096; i++) model[i] = (i * 37 + 11) & 255;
        rst_n = 1'b0;
        start = 1'b0;
        err_count = '0;
        err_pos = '0;
        err_pat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle_check("R1", 0, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        idle_check("R1", 0, 0);

        run_job("R2", 1, '{3, 0, 0, 0},       '{12'hABC, 0, 0, 0}, 1'b0);
        run_job("R3", 1, '{4, 0, 0, 0},       '{12'h5A3, 0, 0, 0}, 1'b0);
        run_job("R4", 1, '{0, 0, 0, 0},       '{12'h07E, 0, 0, 0}, 1'b0);
        run_job("R4", 2, '{7, 0, 0, 0},       '{12'h111, 12'h1FF, 0, 0}, 1'b0);
        run_job("R5", 1, '{1365, 0, 0, 0},    '{12'hF0F, 0, 0, 0}, 1'b0);
        run_job("R6", 3, '{1366, 1374, 1367, 0}, '{12'h123, 12'hFED, 12'h9C6, 0}, 1'b0);
        run_job("R9", 4, '{1, 2, 9, 0},       '{12'h3C5, 12'hA5A, 12'h0F0, 12'h0EE}, 1'b0);
        run_job("R7", 3, '{10, 1375, 5, 0},   '{12'h246, 12'h001, 12'h777, 0}, 1'b0);
        run_job("R7", 1, '{4095, 0, 0, 0},    '{12'h001, 0, 0, 0}, 1'b0);
        run_job("R8", 5, '{1, 2, 3, 4},       '{12'h111, 12'h222, 12'h333, 12'h444}, 1'b0);
        run_job("R10", 0, '{5, 0, 0, 0},      '{12'hFFF, 0, 0, 0}, 1'b0);
        run_job("R11", 2, '{100, 201, 0, 0},  '{12'h8E1, 12'h3D7, 0, 0}, 1'b1);

        bad = 0;
        for (int i = 0; i < 4096; i++) if (int'(mem[i]) != model[i]) bad++;
        check(bad == 0, "R9", "page image mismatches", bad, 0);
        finish_run();
    end
endmodule